// File: doc/BRIEF.md
# Prescaled Baud Tick Generator

This block produces the oversampling enable that paces both the transmit and the receive side of a serial port. The tick runs at sixteen times the bit rate. A reference clock is first thinned by a prescaler that passes every cycle or one cycle in four. A programmable divisor then divides the result, so the tick period is prescale × divisor reference cycles. For a given bit rate the divisor is (f_ref / prescale) / (16 × baud).

The divisor is split into a low byte and a high byte, each written through a small register write port. A control register carries the prescaler choice. A strap input seeds that choice while reset is being released. A divisor of zero silences the tick, and the serial port stalls with it. Any register write restarts the count, so a new setting takes effect at once and an old long count does not have to run out first.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is held and after it is released, `baud_tick_o` is low and the divisor is zero, so no tick appears until a divisor is written.
- R2: The level of `clk_sel_strap_i` during the final cycles of reset release sets the prescaler choice: 1 selects divide-by-4 and 0 selects divide-by-1.
- R3: A write to address 2 sets the prescaler choice from the top bit of `wr_data_i`, where 1 selects divide-by-4 and 0 selects divide-by-1. All other data bits of that write are ignored.
- R4: A write to address 0 loads the low byte of the divisor and a write to address 1 loads the high byte. The divisor is {high, low}, 2×BYTE_W bits wide.
- R5: With a divisor D ≥ 1 and prescale P (1 or 4), successive ticks are exactly P×D reference cycles apart.
- R6: Any write to addresses 0, 1 or 2 restarts the count. The first tick is high exactly P×D+1 rising edges after the edge that takes the write.
- R7: While the divisor is zero, no tick is produced.
- R8: Each tick is one reference cycle wide when P×D > 1. With P×D = 1 the tick stays high on every cycle.
- R9: A write to address 3 changes nothing and does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| clk_sel_strap_i | input | 1 | Prescaler choice captured during reset release |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 low byte, 1 high byte, 2 control, 3 unused |
| wr_data_i | input | BYTE_W | Write data |
| baud_tick_o | output | 1 | 16x baud enable pulse |

## Verification
The bench builds the block with BYTE_W = 3, which gives a 6-bit divisor. Every divisor value from 0 to 63 can then be swept under both prescaler settings in a few tens of thousands of cycles, so first-tick latency, period and pulse width are compared against P×D for the whole range. The junk low bits of the control write, the unused address, and both strap levels across a reset are exercised as well.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    REG_DIV_LO = 2'd0,
    REG_DIV_HI = 2'd1,
    REG_CTRL   = 2'd2,
    REG_SPARE  = 2'd3
  } baud_reg_e;
endpackage

// File: rtl/baud_rst_sync.sv
module baud_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
  import baud_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int DIV_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_n_raw_i,
  input  logic              rst_n_i,
  input  logic              strap_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [DIV_W-1:0]  divisor_o,
  output logic              pre_sel_o,
  output logic              restart_o
);
  localparam int SEL_BIT = BYTE_W - 1;

  logic [BYTE_W-1:0] lo_q, lo_d;
  logic [BYTE_W-1:0] hi_q, hi_d;
  logic              sel_q, sel_d;
  logic              rst_q, rst_d;
  logic              wr_lo, wr_hi, wr_ctl;

  always_comb begin
    wr_lo  = wr_en_i && (baud_reg_e'(wr_addr_i) == REG_DIV_LO);
    wr_hi  = wr_en_i && (baud_reg_e'(wr_addr_i) == REG_DIV_HI);
    wr_ctl = wr_en_i && (baud_reg_e'(wr_addr_i) == REG_CTRL);
    lo_d   = wr_lo ? wr_data_i : lo_q;
    hi_d   = wr_hi ? wr_data_i : hi_q;
    rst_d  = wr_lo || wr_hi || wr_ctl;
    if (!rst_n_i)    sel_d = strap_i;
    else if (wr_ctl) sel_d = wr_data_i[SEL_BIT];
    else             sel_d = sel_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      lo_q  <= '0;
      hi_q  <= '0;
      rst_q <= 1'b0;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      rst_q <= rst_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_raw_i) begin
    if (!rst_n_raw_i) sel_q <= 1'b0;
    else              sel_q <= sel_d;
  end

  assign divisor_o = {hi_q, lo_q};
  assign pre_sel_o = sel_q;
  assign restart_o = rst_q;

  AST_STRAP_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_n_raw_i)
    $rose(rst_n_i) |-> (sel_q == $past(strap_i))); // R2
  AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    wr_ctl |=> (sel_q == $past(wr_data_i[SEL_BIT]))); // R3
  AST_SPARE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_en_i && wr_addr_i == 2'd3) |=> ($stable(divisor_o) && !restart_o)); // R9
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int RATIO = 4,
  localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic sel_i,
  input  logic restart_i,
  output logic en_o
);
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (restart_i)          cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end

  assign en_o = sel_i ? (cnt_q == LAST) : 1'b1;

  AST_PRE_GAP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (sel_i && en_o) |=> (!en_o || !sel_i)); // R5
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic             at_one;

  always_comb begin
    at_one = (cnt_q == DIV_W'(1));
    if (restart_i)
      cnt_d = divisor_i;
    else if (en_i && (cnt_q <= DIV_W'(1)))
      cnt_d = divisor_i;
    else if (en_i)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = cnt_q;
    tick_d = en_i && !restart_i && at_one && (divisor_i != '0);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  AST_ZERO_SILENT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $past(divisor_i == '0) |-> !tick_o); // R7
  AST_RESTART_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    restart_i |=> !tick_o); // R6
  AST_TICK_GATED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    tick_o |-> $past(en_i)); // R5
  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (tick_o && divisor_i != DIV_W'(1)) |=> !tick_o); // R8
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int BYTE_W    = 8,
  parameter int PRE_RATIO = 4,
  parameter int SYNC_LEN  = 2
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              clk_sel_strap_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic              baud_tick_o
);
  localparam int DIV_W = 2 * BYTE_W;

  logic             rst_n_int;
  logic [DIV_W-1:0] divisor;
  logic             pre_sel;
  logic             restart;
  logic             pre_en;

  baud_rst_sync #(.STAGES(SYNC_LEN)) i_rst_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n_int)
  );

  baud_cfg_regs #(.BYTE_W(BYTE_W)) i_cfg (
    .clk_i       (clk_i),
    .rst_n_raw_i (rst_n_i),
    .rst_n_i     (rst_n_int),
    .strap_i     (clk_sel_strap_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .divisor_o   (divisor),
    .pre_sel_o   (pre_sel),
    .restart_o   (restart)
  );

  baud_prescale #(.RATIO(PRE_RATIO)) i_pre (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_int),
    .sel_i     (pre_sel),
    .restart_i (restart),
    .en_o      (pre_en)
  );

  baud_divider #(.DIV_W(DIV_W)) i_div (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_int),
    .en_i      (pre_en),
    .restart_i (restart),
    .divisor_i (divisor),
    .tick_o    (baud_tick_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_n_int |-> !baud_tick_o); // R1
endmodule

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
  localparam int BW = 3;
  localparam int SEL_BIT = BW - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          strap;
  logic          wr_en;
  logic [1:0]    wr_addr;
  logic [BW-1:0] wr_data;
  logic          tick;

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;

  baud_tick_gen #(.BYTE_W(BW)) i_baud_tick_gen (
    .clk_i           (clk),
    .rst_n_i         (rst_n),
    .clk_sel_strap_i (strap),
    .wr_en_i         (wr_en),
    .wr_addr_i       (wr_addr),
    .wr_data_i       (wr_data),
    .baud_tick_o     (tick)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [BW-1:0] d, output int t0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    t0 = cyc;
  endtask

  task automatic wait_tick(input int limit, output int at);
    int g = 0;
    at = -1;
    while (g < limit) begin
      @(negedge clk);
      g++;
      if (tick) begin at = cyc; break; end
    end
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0; strap = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_div(input int d, output int t0);
    int tl;
    wr(2'd0, BW'(d), tl);
    wr(2'd1, BW'(d >> BW), t0);
  endtask

  task automatic measure(input int p, input int d, input int t0, input string req);
    int a1, a2, pd;
    pd = p * d;
    wait_tick(pd + 8, a1);
    check(a1 - t0 == pd + 1, req, a1 - t0, pd + 1); // R6
    if (pd > 1) begin
      @(negedge clk);
      check(!tick, "R8", int'(tick), 0);
      wait_tick(pd + 8, a2);
      check(a2 - a1 == pd, "R5", a2 - a1, pd);
    end else begin
      @(negedge clk);
      check(tick, "R8", int'(tick), 1);
    end
  endtask

  initial begin
    int t0, at, tt;
    bit seen;
    rst_n = 1'b0; strap = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;

    // R1: quiet in and after reset
    repeat (3) @(negedge clk);
    check(!tick, "R1", int'(tick), 0);
    rst_n = 1'b1;
    seen = 1'b0;
    repeat (100) begin @(negedge clk); if (tick) seen = 1'b1; end
    check(!seen, "R1", int'(seen), 0);

    // R3, R4, R5, R6, R7, R8: full sweep of both prescalers and all divisors
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < (1 << (2 * BW)); d++) begin
        wr(2'd2, BW'((s << SEL_BIT) | (d & ((1 << SEL_BIT) - 1))), tt);
        set_div(d, t0);
        if (d == 0) begin
          seen = 1'b0;
          repeat (200) begin @(negedge clk); if (tick) seen = 1'b1; end
          check(!seen, "R7", int'(seen), 0);
        end else begin
          measure(s ? 4 : 1, d, t0, s ? "R3 R4" : "R4");
        end
      end
    end

    // R9: spare address neither changes divisor nor restarts
    wr(2'd2, '0, tt);
    set_div(20, t0);
    repeat (5) @(negedge clk);
    wr(2'd3, '1, tt);
    wait_tick(60, at);
    check(at - t0 == 21, "R9", at - t0, 21);
    wait_tick(60, tt);
    check(tt - at == 20, "R9", tt - at, 20);

    // R6: control write alone restarts
    wr(2'd2, BW'(1 << SEL_BIT), t0);
    measure(4, 20, t0, "R6");

    // R2: strap sets prescaler after reset
    do_reset(1'b1);
    set_div(7, t0);
    measure(4, 7, t0, "R2");
    do_reset(1'b0);
    set_div(7, t0);
    measure(1, 7, t0, "R2");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule